// File: doc/BRIEF.md
# Single-Phase RMS and Average Power Engine

This block sits behind the decimation filters of a single-phase metering front end. Each valid strobe delivers one signed voltage sample and one signed current sample. Both are 24-bit fixed point, from -1 to just under +1. Each channel is calibrated by adding a signed DC offset and then scaling by an unsigned gain. The calibrated pair is held on the instantaneous outputs until the next strobe.

Over a programmable cycle of N samples the block sums the squared voltage, the squared current and their product. When the N-th sample of a cycle arrives, the three sums are frozen and handed to a sequential math unit. This unit divides each sum by N and takes the square root of the two mean squares, one result bit per clock. It then adds a per-channel AC offset to each root and a power offset to the mean product. All three results are published together, with a one-clock valid pulse.

Top module: `pwr_meas_core`

## Requirements
- R1: One clock after a strobe, `v_inst` equals the voltage calibration result and `i_inst` the current calibration result. The calibration result is floor(((raw + dc_offset) * gain) / 2^22), where gain is unsigned with 22 fraction bits (0x400000 = 1.0). It is saturated to the signed range -0x800000 to 0x7FFFFF.
- R2: Without a strobe, `v_inst` and `i_inst` hold their values, whatever the raw inputs do.
- R3: A cycle is published after its N-th strobe and not before. N is `cyc_len` taken at the first strobe of the cycle. A value of 0 acts as 1, and a value above 4096 acts as 4096.
- R4: `v_rms` = floor(sqrt(floor(sum of v_inst^2 / N))) + `v_ac_ofs`, clamped to the range 0 to 0x7FFFFF. `i_rms` is formed the same way from the current samples and `i_ac_ofs`.
- R5: `p_avg` is s * floor(floor(|S| / N) / 2^23) + `p_ofs`, saturated to the signed 24-bit range. Here S is the sum of v_inst*i_inst over the cycle and s is the sign of S.
- R6: `res_valid` is high for exactly one clock per published cycle. `v_rms`, `i_rms` and `p_avg` change only in that clock.
- R7: The results of each cycle depend only on the samples of that cycle.
- R8: A synchronous `rst` clears the instantaneous values, the sums, the cycle count and all results to zero, and restarts cycle counting.
- R9: A change of `cyc_len` in the middle of a cycle does not alter that cycle's length. It applies from the following cycle.
- R10: If a cycle completes while the previous cycle's results are still being computed, the newer cycle is dropped. Accumulation continues without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One sample pair present this clock |
| v_raw | input | 24 | Raw voltage sample, signed |
| i_raw | input | 24 | Raw current sample, signed |
| v_dc_ofs | input | 24 | Voltage DC offset, signed |
| i_dc_ofs | input | 24 | Current DC offset, signed |
| v_gain | input | 24 | Voltage gain, unsigned 2.22 |
| i_gain | input | 24 | Current gain, unsigned 2.22 |
| v_ac_ofs | input | 24 | Offset added to the voltage root, signed |
| i_ac_ofs | input | 24 | Offset added to the current root, signed |
| p_ofs | input | 24 | Offset added to average power, signed |
| cyc_len | input | 13 | Samples per cycle N |
| v_inst | output | 24 | Calibrated voltage, signed |
| i_inst | output | 24 | Calibrated current, signed |
| v_rms | output | 24 | RMS voltage result |
| i_rms | output | 24 | RMS current result |
| p_avg | output | 24 | Average active power, signed |
| res_valid | output | 1 | Results updated this clock |

## Verification
The situation hardest to reach from the ports is a cycle boundary that falls while the math unit is still busy. It only arises when cycles are far shorter than the divide-and-root latency. The bench forces it with N = 1 and three strobes on consecutive clocks. It then expects exactly one publication, carrying the first sample. A second hard case is a change of `cyc_len` in the middle of a cycle: the bench rewrites it after two strobes and checks that the cycle still closes on the old count.

// File: rtl/pwr_meas_pkg.sv
package pwr_meas_pkg;
    localparam int SMP_W     = 24;
    localparam int GAIN_W    = 24;
    localparam int GAIN_FRAC = 22;
    localparam int MAX_N     = 4096;
    localparam int NCFG_W    = 13;
    localparam int NCNT_W    = $clog2(MAX_N + 1);
    localparam int SQ_W      = 2 * SMP_W;
    localparam int ACC_W     = SQ_W + $clog2(MAX_N);
    localparam int ROOT_W    = SQ_W / 2;
    localparam int NCH       = 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [ACC_W-1:0]        acc_u_t;
    typedef logic signed [ACC_W-1:0] acc_s_t;

    typedef struct packed {
        acc_u_t              vv;
        acc_u_t              ii;
        acc_s_t              vi;
        logic [NCNT_W-1:0]   n;
    } snap_t;

    typedef enum logic [2:0] {
        PS_IDLE, PS_DIV_V, PS_DIV_I, PS_DIV_P, PS_SQ_V, PS_SQ_I, PS_PUB
    } post_st_e;

    function automatic smp_t sat_smp(input logic signed [63:0] x);
        logic signed [63:0] hi, lo;
        hi = (64'sd1 <<< (SMP_W - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (SMP_W - 1));
        if (x > hi) return hi[SMP_W-1:0];
        if (x < lo) return lo[SMP_W-1:0];
        return x[SMP_W-1:0];
    endfunction

    function automatic logic [SMP_W-1:0] sat_mag(input logic signed [63:0] x);
        logic signed [63:0] hi;
        hi = (64'sd1 <<< (SMP_W - 1)) - 64'sd1;
        if (x > hi) return hi[SMP_W-1:0];
        if (x < 64'sd0) return '0;
        return x[SMP_W-1:0];
    endfunction

    function automatic logic [NCNT_W-1:0] clamp_n(input logic [NCFG_W-1:0] req);
        if (req == '0) return NCNT_W'(1);
        if (int'(req) > MAX_N) return NCNT_W'(MAX_N);
        return NCNT_W'(req);
    endfunction
endpackage

// File: rtl/pwr_meas_cal.sv
module pwr_meas_cal
    import pwr_meas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld,
    input  smp_t              raw,
    input  smp_t              dc_ofs,
    input  logic [GAIN_W-1:0] gain,
    output smp_t              cal_q
);
    localparam int PW = SMP_W + GAIN_W + 2;

    logic signed [SMP_W:0]  biased;
    logic signed [PW-1:0]   prod;
    logic signed [63:0]     scaled;

    // offset first, then gain, then saturate
    always_comb begin
        biased = {raw[SMP_W-1], raw} + {dc_ofs[SMP_W-1], dc_ofs};
        prod   = PW'(biased) * $signed(PW'({1'b0, gain}));
        scaled = $signed({{(64-PW){prod[PW-1]}}, prod}) >>> GAIN_FRAC;
    end

    always_ff @(posedge clk) begin
        if (rst)      cal_q <= '0;
        else if (vld) cal_q <= sat_smp(scaled);
    end
endmodule

// File: rtl/pwr_meas_acc.sv
module pwr_meas_acc
    import pwr_meas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  smp_t              v,
    input  smp_t              i,
    input  logic [NCFG_W-1:0] n_req,
    output logic              snap_vld,
    output snap_t             snap
);
    logic [NCNT_W-1:0]      cnt_q, n_q, n_eff;
    acc_u_t                 vv_q, ii_q, vv_nx, ii_nx;
    acc_s_t                 vi_q, vi_nx;
    logic signed [SQ_W-1:0] p_vv, p_ii, p_vi;
    logic                   first, last;

    always_comb begin
        p_vv  = SQ_W'(v) * SQ_W'(v);
        p_ii  = SQ_W'(i) * SQ_W'(i);
        p_vi  = SQ_W'(v) * SQ_W'(i);
        first = (cnt_q == '0);
        n_eff = first ? clamp_n(n_req) : n_q;
        vv_nx = (first ? '0 : vv_q) + {{(ACC_W-SQ_W){1'b0}}, p_vv};
        ii_nx = (first ? '0 : ii_q) + {{(ACC_W-SQ_W){1'b0}}, p_ii};
        vi_nx = (first ? '0 : vi_q) + ACC_W'(p_vi);
        last  = ((cnt_q + NCNT_W'(1)) == n_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            n_q      <= '0;
            vv_q     <= '0;
            ii_q     <= '0;
            vi_q     <= '0;
            snap_vld <= 1'b0;
            snap     <= '0;
        end else begin
            snap_vld <= 1'b0;
            if (in_vld) begin
                n_q  <= n_eff;
                vv_q <= vv_nx;
                ii_q <= ii_nx;
                vi_q <= vi_nx;
                if (last) begin
                    cnt_q    <= '0;
                    snap_vld <= 1'b1;
                    snap     <= '{vv: vv_nx, ii: ii_nx, vi: vi_nx, n: n_eff};
                end else begin
                    cnt_q <= cnt_q + NCNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwr_meas_div.sv
module pwr_meas_div #(
    parameter int DW = 60,
    parameter int NW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [NW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CW = $clog2(DW + 1);

    logic [NW-1:0] rem_q, dvs_q;
    logic [DW-1:0] shf_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [NW:0]   trial;
    logic          fits;

    assign trial    = {rem_q, shf_q[DW-1]};
    assign fits     = (trial >= {1'b0, dvs_q});
    assign quotient = shf_q;

    // restoring division, one quotient bit per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dvs_q <= '0;
            shf_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run_q) begin
                rem_q <= '0;
                shf_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? NW'(trial - {1'b0, dvs_q}) : trial[NW-1:0];
                shf_q <= {shf_q[DW-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwr_meas_isqrt.sv
module pwr_meas_isqrt #(
    parameter int IW = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   radicand,
    output logic            done,
    output logic [IW/2-1:0] root
);
    localparam int OW = IW / 2;
    localparam int CW = $clog2(OW + 1);

    logic [IW-1:0] op_q, res_q, bit_q, cand;
    logic [CW-1:0] cnt_q;
    logic          run_q, ge;

    assign cand = res_q + bit_q;
    assign ge   = (op_q >= cand);
    assign root = res_q[OW-1:0];

    // digit-by-digit root, one result bit per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            res_q <= '0;
            bit_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run_q) begin
                op_q  <= radicand;
                res_q <= '0;
                bit_q <= {2'b01, {(IW-2){1'b0}}};
                cnt_q <= CW'(OW);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (ge) begin
                    op_q  <= op_q - cand;
                    res_q <= (res_q >> 1) + bit_q;
                end else begin
                    res_q <= res_q >> 1;
                end
                bit_q <= bit_q >> 2;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwr_meas_post.sv
module pwr_meas_post
    import pwr_meas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_vld,
    input  snap_t            snap,
    input  smp_t             v_ac_ofs,
    input  smp_t             i_ac_ofs,
    input  smp_t             p_ofs,
    output logic             res_vld,
    output logic [SMP_W-1:0] v_rms,
    output logic [SMP_W-1:0] i_rms,
    output smp_t             p_avg
);
    post_st_e           st_q;
    snap_t              hold_q;
    logic               launched_q;
    logic [SQ_W-1:0]    ms_v_q, ms_i_q, rad;
    acc_u_t             pq_q, dvd, vi_mag, div_q;
    logic [ROOT_W-1:0]  rt_v_q, rt_i_q, sq_root;
    logic               neg, in_div, in_sq, div_start, sq_start, div_done, sq_done;
    logic signed [63:0] v_sum, i_sum, p_sum;
    logic [63:0]        p_mag;

    always_comb begin
        neg       = hold_q.vi[ACC_W-1];
        vi_mag    = neg ? (acc_u_t'(~hold_q.vi) + acc_u_t'(1)) : acc_u_t'(hold_q.vi);
        in_div    = (st_q == PS_DIV_V) || (st_q == PS_DIV_I) || (st_q == PS_DIV_P);
        in_sq     = (st_q == PS_SQ_V) || (st_q == PS_SQ_I);
        div_start = in_div && !launched_q;
        sq_start  = in_sq && !launched_q;
        case (st_q)
            PS_DIV_V: dvd = hold_q.vv;
            PS_DIV_I: dvd = hold_q.ii;
            default:  dvd = vi_mag;
        endcase
        rad   = (st_q == PS_SQ_V) ? ms_v_q : ms_i_q;
        v_sum = $signed(64'(rt_v_q)) + 64'(v_ac_ofs);
        i_sum = $signed(64'(rt_i_q)) + 64'(i_ac_ofs);
        p_mag = 64'(pq_q >> (SMP_W - 1));
        p_sum = (neg ? -$signed(p_mag) : $signed(p_mag)) + 64'(p_ofs);
    end

    pwr_meas_div #(.DW(ACC_W), .NW(NCNT_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .dividend(dvd),
        .divisor(hold_q.n), .done(div_done), .quotient(div_q)
    );

    pwr_meas_isqrt #(.IW(SQ_W)) u_sqrt (
        .clk(clk), .rst(rst), .start(sq_start), .radicand(rad),
        .done(sq_done), .root(sq_root)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_IDLE;
            hold_q     <= '0;
            launched_q <= 1'b0;
            ms_v_q     <= '0;
            ms_i_q     <= '0;
            pq_q       <= '0;
            rt_v_q     <= '0;
            rt_i_q     <= '0;
            res_vld    <= 1'b0;
            v_rms      <= '0;
            i_rms      <= '0;
            p_avg      <= '0;
        end else begin
            res_vld <= 1'b0;
            if (div_start || sq_start) launched_q <= 1'b1;
            case (st_q)
                PS_IDLE: if (snap_vld) begin
                    hold_q <= snap;
                    st_q   <= PS_DIV_V;
                end
                PS_DIV_V: if (launched_q && div_done) begin
                    ms_v_q     <= (|div_q[ACC_W-1:SQ_W]) ? '1 : div_q[SQ_W-1:0];
                    launched_q <= 1'b0;
                    st_q       <= PS_DIV_I;
                end
                PS_DIV_I: if (launched_q && div_done) begin
                    ms_i_q     <= (|div_q[ACC_W-1:SQ_W]) ? '1 : div_q[SQ_W-1:0];
                    launched_q <= 1'b0;
                    st_q       <= PS_DIV_P;
                end
                PS_DIV_P: if (launched_q && div_done) begin
                    pq_q       <= div_q;
                    launched_q <= 1'b0;
                    st_q       <= PS_SQ_V;
                end
                PS_SQ_V: if (launched_q && sq_done) begin
                    rt_v_q     <= sq_root;
                    launched_q <= 1'b0;
                    st_q       <= PS_SQ_I;
                end
                PS_SQ_I: if (launched_q && sq_done) begin
                    rt_i_q     <= sq_root;
                    launched_q <= 1'b0;
                    st_q       <= PS_PUB;
                end
                PS_PUB: begin
                    v_rms   <= sat_mag(v_sum);
                    i_rms   <= sat_mag(i_sum);
                    p_avg   <= sat_smp(p_sum);
                    res_vld <= 1'b1;
                    st_q    <= PS_IDLE;
                end
                default: st_q <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwr_meas_core.sv
module pwr_meas_core
    import pwr_meas_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] v_raw,
    input  logic signed [SMP_W-1:0] i_raw,
    input  logic signed [SMP_W-1:0] v_dc_ofs,
    input  logic signed [SMP_W-1:0] i_dc_ofs,
    input  logic [GAIN_W-1:0]       v_gain,
    input  logic [GAIN_W-1:0]       i_gain,
    input  logic signed [SMP_W-1:0] v_ac_ofs,
    input  logic signed [SMP_W-1:0] i_ac_ofs,
    input  logic signed [SMP_W-1:0] p_ofs,
    input  logic [NCFG_W-1:0]       cyc_len,
    output logic signed [SMP_W-1:0] v_inst,
    output logic signed [SMP_W-1:0] i_inst,
    output logic [SMP_W-1:0]        v_rms,
    output logic [SMP_W-1:0]        i_rms,
    output logic signed [SMP_W-1:0] p_avg,
    output logic                    res_valid
);
    smp_t              raw_a  [NCH];
    smp_t              ofs_a  [NCH];
    logic [GAIN_W-1:0] gain_a [NCH];
    smp_t              cal_a  [NCH];
    logic              inst_vld_q;
    logic              snap_vld;
    snap_t             snap;

    assign raw_a[0]  = v_raw;
    assign raw_a[1]  = i_raw;
    assign ofs_a[0]  = v_dc_ofs;
    assign ofs_a[1]  = i_dc_ofs;
    assign gain_a[0] = v_gain;
    assign gain_a[1] = i_gain;
    assign v_inst    = cal_a[0];
    assign i_inst    = cal_a[1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwr_meas_cal u_cal (
            .clk(clk), .rst(rst), .vld(smp_valid), .raw(raw_a[c]),
            .dc_ofs(ofs_a[c]), .gain(gain_a[c]), .cal_q(cal_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) inst_vld_q <= 1'b0;
        else     inst_vld_q <= smp_valid;
    end

    pwr_meas_acc u_acc (
        .clk(clk), .rst(rst), .in_vld(inst_vld_q), .v(cal_a[0]), .i(cal_a[1]),
        .n_req(cyc_len), .snap_vld(snap_vld), .snap(snap)
    );

    pwr_meas_post u_post (
        .clk(clk), .rst(rst), .snap_vld(snap_vld), .snap(snap),
        .v_ac_ofs(v_ac_ofs), .i_ac_ofs(i_ac_ofs), .p_ofs(p_ofs),
        .res_vld(res_valid), .v_rms(v_rms), .i_rms(i_rms), .p_avg(p_avg)
    );
endmodule

// File: rtl/pwr_meas_chk.sv
module pwr_meas_chk
    import pwr_meas_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic signed [SMP_W-1:0] v_inst,
    input logic signed [SMP_W-1:0] i_inst,
    input logic [SMP_W-1:0]        v_rms,
    input logic [SMP_W-1:0]        i_rms,
    input logic signed [SMP_W-1:0] p_avg,
    input logic                    res_valid
);
    // R8: reset leaves every result and instantaneous value at zero
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (v_rms == '0 && i_rms == '0 && p_avg == '0 && !res_valid
                 && v_inst == '0 && i_inst == '0));

    // R6: results-valid lasts one clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R6: results move only together with the valid pulse
    a_r6_results_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(v_rms) && $stable(i_rms) && $stable(p_avg)));

    // R2: calibrated values hold between strobes
    a_r2_inst_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(v_inst) && $stable(i_inst)));

    // R4: RMS outputs never carry a negative value
    a_r4_rms_nonneg: assert property (@(posedge clk) disable iff (rst)
        !v_rms[SMP_W-1] && !i_rms[SMP_W-1]);
endmodule

bind pwr_meas_core pwr_meas_chk chk_i (.*);

// File: tb/pwr_meas_core_tb_top.sv
module pwr_meas_core_tb_top;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [23:0] v_raw = '0, i_raw = '0, v_dc_ofs = '0, i_dc_ofs = '0;
    logic [23:0]        v_gain = 24'h400000, i_gain = 24'h400000;
    logic signed [23:0] v_ac_ofs = '0, i_ac_ofs = '0, p_ofs = '0;
    logic [12:0]        cyc_len = 13'd4;
    logic signed [23:0] v_inst, i_inst, p_avg;
    logic [23:0]        v_rms, i_rms;
    logic               res_valid;

    int n_chk = 0;
    int n_fail = 0;
    int pub_cnt = 0;
    longint m_vv = 0, m_ii = 0, m_vi = 0;
    int m_cnt = 0, m_n = 1;
    longint e_v = 0, e_i = 0, e_p = 0;
    logic e_rdy = 1'b0;
    int lcg = 12345;

    pwr_meas_core dut_i (.*);

    always #5 clk = ~clk;

    always @(negedge clk) if (res_valid) pub_cnt++;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat24(input longint x);
        if (x > 64'sh7FFFFF) return 64'sh7FFFFF;
        if (x < -64'sh800000) return -64'sh800000;
        return x;
    endfunction

    function automatic longint m_cal(input longint raw, input longint ofs, input longint g);
        return sat24(((raw + ofs) * g) >>> 22);
    endfunction

    function automatic longint isqrt(input longint x);
        longint lo = 0, hi = 64'sh1000000, mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= x) lo = mid; else hi = mid - 1;
        end
        return lo;
    endfunction

    function automatic longint m_rms(input longint s, input int n, input longint ofs);
        longint x = isqrt(s / n) + ofs;
        if (x > 64'sh7FFFFF) return 64'sh7FFFFF;
        if (x < 0) return 0;
        return x;
    endfunction

    function automatic longint m_pwr(input longint s, input int n, input longint ofs);
        longint mag = (s < 0) ? -s : s;
        longint q = (mag / n) >>> 23;
        return sat24(((s < 0) ? -q : q) + ofs);
    endfunction

    function automatic int clampn(input int r);
        if (r == 0) return 1;
        if (r > 4096) return 4096;
        return r;
    endfunction

    task automatic model_add(input longint cv, input longint ci);
        if (m_cnt == 0) begin
            m_n = clampn(int'(cyc_len));
            m_vv = 0; m_ii = 0; m_vi = 0;
        end
        m_vv += cv * cv; m_ii += ci * ci; m_vi += cv * ci;
        m_cnt++;
        if (m_cnt == m_n) begin
            e_v = m_rms(m_vv, m_n, longint'(v_ac_ofs));
            e_i = m_rms(m_ii, m_n, longint'(i_ac_ofs));
            e_p = m_pwr(m_vi, m_n, longint'(p_ofs));
            e_rdy = 1'b1;
            m_cnt = 0;
        end
    endtask

    // aligned at a negedge on entry and exit
    task automatic push(input longint v, input longint i);
        longint cv, ci;
        v_raw = 24'(v); i_raw = 24'(i); smp_valid = 1'b1;
        cv = m_cal(longint'(v_raw), longint'(v_dc_ofs), longint'({40'd0, v_gain}));
        ci = m_cal(longint'(i_raw), longint'(i_dc_ofs), longint'({40'd0, i_gain}));
        model_add(cv, ci);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; e_rdy = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_pub(input string req);
        int k = 0;
        while (!res_valid && k < 2000) begin @(negedge clk); k++; end
        chk({req, " publish seen"}, longint'(res_valid), 1);
        chk({req, " v_rms"}, longint'(v_rms), e_v);
        chk({req, " i_rms"}, longint'(i_rms), e_i);
        chk({req, " p_avg"}, longint'(p_avg), e_p);
        e_rdy = 1'b0;
        @(negedge clk);
    endtask

    function automatic longint rnd();
        lcg = lcg * 1103515245 + 12345;
        return longint'(lcg >>> 8) % 64'sh7FFFFF;
    endfunction

    task automatic t_reset();
        chk("R8 reset v_inst", longint'(v_inst), 0);
        chk("R8 reset i_inst", longint'(i_inst), 0);
        chk("R8 reset v_rms", longint'(v_rms), 0);
        chk("R8 reset p_avg", longint'(p_avg), 0);
        chk("R8 reset res_valid", longint'(res_valid), 0);
    endtask

    task automatic t_calib();
        cyc_len = 13'd4095;
        v_dc_ofs = 24'sd1000; i_dc_ofs = -24'sd2000;
        v_gain = 24'h400000; i_gain = 24'h600000;
        push(300000, -400000);
        chk("R1 v_inst", longint'(v_inst), m_cal(300000, 1000, 64'h400000));
        chk("R1 i_inst", longint'(i_inst), m_cal(-400000, -2000, 64'h600000));
        v_gain = 24'h2AAAAB; i_dc_ofs = 24'sd77;
        push(-123457, 5);
        chk("R1 v_inst frac gain", longint'(v_inst), m_cal(-123457, 1000, 64'h2AAAAB));
        chk("R1 i_inst small", longint'(i_inst), m_cal(5, 77, 64'h600000));
        v_raw = 24'sd999; i_raw = -24'sd999;
        repeat (3) @(negedge clk);
        chk("R2 v_inst hold", longint'(v_inst), m_cal(-123457, 1000, 64'h2AAAAB));
        chk("R2 i_inst hold", longint'(i_inst), m_cal(5, 77, 64'h600000));
    endtask

    task automatic t_sat();
        v_dc_ofs = 24'sh100000; v_gain = 24'h800000;
        i_dc_ofs = -24'sh100000; i_gain = 24'hFFFFFF;
        push(24'sh7FFFFF, -24'sh800000);
        chk("R1 sat high", longint'(v_inst), 64'sh7FFFFF);
        chk("R1 sat low", longint'(i_inst), -64'sh800000);
    endtask

    task automatic neutral();
        v_dc_ofs = '0; i_dc_ofs = '0; v_gain = 24'h400000; i_gain = 24'h400000;
        v_ac_ofs = '0; i_ac_ofs = '0; p_ofs = '0;
    endtask

    task automatic t_cycle();
        int base;
        neutral(); cyc_len = 13'd5; do_reset();
        base = pub_cnt;
        for (int k = 0; k < 4; k++) push(rnd(), -rnd());
        repeat (400) @(negedge clk);
        chk("R3 no publish before N", longint'(pub_cnt - base), 0);
        push(rnd(), rnd());
        wait_pub("R4 R5 basic");
        chk("R6 pulse one clock", longint'(res_valid), 0);
        repeat (10) @(negedge clk);
        chk("R6 v_rms held", longint'(v_rms), e_v);
        chk("R6 single publish", longint'(pub_cnt - base), 1);
    endtask

    task automatic t_offsets();
        v_dc_ofs = 24'sd5000; i_dc_ofs = -24'sd300; v_gain = 24'h380000; i_gain = 24'h480000;
        v_ac_ofs = -24'sh7FFFFF; i_ac_ofs = 24'sd4321; p_ofs = -24'sd17;
        cyc_len = 13'd3;
        for (int k = 0; k < 3; k++) push(rnd(), -rnd());
        wait_pub("R4 R5 offsets negative power");
        chk("R4 ac offset clamps to zero", longint'(v_rms), 0);
        v_ac_ofs = 24'sh7FFFFF; p_ofs = 24'sh7FFFFF;
        for (int k = 0; k < 3; k++) push(rnd(), rnd());
        wait_pub("R4 R5 offsets clamp high");
    endtask

    task automatic t_clear();
        neutral(); cyc_len = 13'd4;
        for (int k = 0; k < 4; k++) push(24'sh700000, 24'sh700000);
        wait_pub("R7 first cycle");
        for (int k = 0; k < 4; k++) push(24'sd1000, -24'sd2000);
        wait_pub("R7 second cycle own data");
    endtask

    task automatic t_nchange();
        int base;
        cyc_len = 13'd6;
        push(rnd(), rnd()); push(rnd(), rnd());
        cyc_len = 13'd3;
        base = pub_cnt;
        push(rnd(), rnd());
        repeat (400) @(negedge clk);
        chk("R9 old N still applies", longint'(pub_cnt - base), 0);
        for (int k = 0; k < 3; k++) push(rnd(), -rnd());
        wait_pub("R9 six-sample cycle");
        for (int k = 0; k < 3; k++) push(rnd(), rnd());
        wait_pub("R9 new N from next cycle");
    endtask

    task automatic t_nclamp();
        int base;
        cyc_len = 13'd0;
        push(-24'sd777777, 24'sd12345);
        wait_pub("R3 zero acts as one");
        chk("R3 single sample rms", longint'(v_rms), 777777);
        cyc_len = 13'd5000;
        base = pub_cnt;
        for (int k = 0; k < 4095; k++) push(24'sd3000 + k, -24'sd500);
        repeat (300) @(negedge clk);
        chk("R3 none before 4096", longint'(pub_cnt - base), 0);
        push(24'sd1, 24'sd1);
        wait_pub("R3 large N clamps to 4096");
    endtask

    task automatic t_overrun();
        int base;
        neutral(); cyc_len = 13'd1;
        base = pub_cnt;
        v_raw = 24'sd400000; i_raw = 24'sd100000; smp_valid = 1'b1;
        @(negedge clk);
        v_raw = 24'sd50; i_raw = 24'sd60;
        @(negedge clk);
        v_raw = 24'sd70; i_raw = 24'sd80;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (600) @(negedge clk);
        chk("R10 only first cycle published", longint'(pub_cnt - base), 1);
        chk("R10 v_rms from first sample", longint'(v_rms), 400000);
        chk("R10 p_avg from first sample", longint'(p_avg),
            m_pwr(64'd400000 * 64'd100000, 1, 0));
        m_cnt = 0;
    endtask

    task automatic t_midreset();
        cyc_len = 13'd4;
        push(24'sh7FFFFF, 24'sh7FFFFF); push(24'sh7FFFFF, 24'sh7FFFFF);
        do_reset();
        chk("R8 mid reset v_rms", longint'(v_rms), 0);
        chk("R8 mid reset v_inst", longint'(v_inst), 0);
        for (int k = 0; k < 4; k++) push(24'sd20000, -24'sd30000);
        wait_pub("R8 restart after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_calib();
        t_sat();
        t_cycle();
        t_offsets();
        t_clear();
        t_nchange();
        t_nclamp();
        t_overrun();
        t_midreset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule